// File: doc/BRIEF.md
# Keyed Flash Command Register Front-End

This block is the register interface that software sees in front of an on-chip flash array. It decodes a simple 32-bit bus (address, write strobe, read strobe, write data, combinational read data). It turns a correctly keyed command write into a single-cycle start strobe with a held opcode and argument for a flash engine. It then tracks the engine's busy period until the engine reports completion with a done pulse and a 32-bit result.

A status word collects readiness, command rejection, lock and flash faults and four ECC event flags, each flag with its own clearing rule. A write-protection register, itself guarded by a 24-bit key, can freeze the mode register. The mode register drives the flash timing and optimisation controls. The flash array, its ECC logic and its program and erase timing sit outside the block and appear here only as input pins.

Top module: `flash_cmd_frontend`

## Requirements
- R1: A write to offset 0x04 acts as a command only when bits [31:24] equal 0x5A; with any other key byte no start strobe is issued and no error flag is set.
- R2: An accepted command raises `eng_start` for exactly one cycle, in the cycle after the bus write. `eng_opcode` takes the write's bits [7:0] and `eng_arg` takes bits [23:8], and both hold those values until the next launch.
- R3: Status bit 0 (ready) goes low together with `eng_start` and returns high after the first `eng_done` pulse. That pulse also captures `eng_result` into the result register at offset 0x0C.
- R4: Status bit 1 (command error) is set by a keyed write whose opcode is undefined (defined: 0x00–0x05, 0x07–0x15), and also by any keyed write while an operation is in progress. Neither case launches anything. The flag clears on a status read or on any write to offset 0x04, and setting takes priority.
- R5: Status bit 2 (lock error) latches `eng_lock_err`. Bits 16–19 latch `ecc_err[0..3]`, which are single and multiple errors on the low data half, then single and multiple errors on the high data half. All of these are sticky and clear on a status read, and a set in the same cycle as the read wins.
- R6: Status bit 3 (flash error) latches `eng_flash_err`. It is not cleared by reads, only when a new command is launched.
- R7: The write-protection register at 0xE4 updates its enable (bit 0) only when bits [31:8] equal 0x454643. It reads back as the enable alone, with bits [31:1] zero.
- R8: The mode register at 0x00 holds the ready-interrupt enable in bit 0, the wait-state count in [11:8], the sequential-optimisation disable in bit 16 and the loop-optimisation enable in bit 26. It drives the `cfg_*` outputs, and writes to it are ignored while write protection is enabled.
- R9: Offset 0x14 reads the VERSION parameter in bits [11:0] and the FIX parameter in bits [18:16]. Unmapped offsets read zero.
- R10: `irq` is high exactly when the block is ready and the ready-interrupt enable is set.
- R11: After reset, status reads 0x00000001, mode, protection and result read zero, and `eng_start` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives read-clear side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| eng_start | output | 1 | One-cycle launch strobe to the flash engine |
| eng_opcode | output | 8 | Opcode of the launched command |
| eng_arg | output | 16 | Argument of the launched command |
| eng_done | input | 1 | Engine completion pulse |
| eng_result | input | 32 | Engine result, captured on done |
| eng_lock_err | input | 1 | Engine lock-violation event |
| eng_flash_err | input | 1 | Engine program/erase failure event |
| ecc_err | input | 4 | ECC events: low single, low multiple, high single, high multiple |
| cfg_ws | output | 4 | Flash wait-state count |
| cfg_seq_dis | output | 1 | Sequential-access optimisation disable |
| cfg_loop_en | output | 1 | Code-loop optimisation enable |
| irq | output | 1 | Ready interrupt |

## Verification
The hardest situation to reach is a correctly keyed, well-formed command arriving while the engine is still busy. It is only legal to reject it in the narrow window between a launch and the engine's done pulse. The bench's engine stub holds done off for ten cycles after each start, which lets the stimulus launch a command, read status and then issue a second keyed command inside that window. A second awkward case is a sticky ECC event arriving in the same cycle as the status read that would clear it. The stimulus drives the event and the read strobe on the same clock edge, then reads again to see which one prevailed.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_RES  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_VER  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PROT = 8'hE4;

  localparam logic [7:0]  CMD_KEY  = 8'h5A;
  localparam logic [23:0] PROT_KEY = 24'h454643;

  localparam int unsigned ECC_BASE = 16;
  localparam int unsigned ECC_N    = 4;
  localparam int unsigned WS_W     = 4;

  typedef struct packed {
    logic            rdy_ie;
    logic [WS_W-1:0] ws;
    logic            seq_dis;
    logic            loop_en;
  } mode_t;

  // Defined opcode set: 0x00..0x05 and 0x07..0x15
  function automatic logic op_defined(input logic [7:0] op);
    return (op <= 8'h15) && (op != 8'h06);
  endfunction

endpackage

// File: rtl/fcmd_cfg.sv
module fcmd_cfg
  import fcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_i,
  input  logic        mode_wr,
  input  logic        prot_wr,
  input  logic        wd_ie,
  input  logic [3:0]  wd_ws,
  input  logic        wd_seq,
  input  logic        wd_loop,
  input  logic [23:0] wd_pkey,
  output mode_t       mode_q,
  output logic        prot_en_q
);

  mode_t mode_d;
  logic  prot_d;
  logic  mode_ce;
  logic  prot_ce;

  always_comb begin
    mode_ce = mode_wr && !prot_en_q;
    prot_ce = prot_wr && (wd_pkey == PROT_KEY);
    mode_d  = mode_q;
    prot_d  = prot_en_q;
    if (mode_ce) begin
      mode_d.rdy_ie  = wd_ie;
      mode_d.ws      = wd_ws;
      mode_d.seq_dis = wd_seq;
      mode_d.loop_en = wd_loop;
    end
    if (prot_ce) prot_d = wd_ie;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mode_q    <= '0;
      prot_en_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      prot_en_q <= prot_d;
    end
  end

endmodule

// File: rtl/fcmd_launch.sv
module fcmd_launch
  import fcmd_pkg::*;
#(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned ARG_W = 16,
  parameter int unsigned RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             cmd_wr,
  input  logic [7:0]       wd_key,
  input  logic [OP_W-1:0]  wd_op,
  input  logic [ARG_W-1:0] wd_arg,
  input  logic             eng_done,
  input  logic [RES_W-1:0] eng_result,
  output logic             launch,
  output logic             reject,
  output logic             busy_q,
  output logic             start_q,
  output logic [OP_W-1:0]  op_q,
  output logic [ARG_W-1:0] arg_q,
  output logic [RES_W-1:0] res_q
);

  logic             keyed;
  logic             op_ok;
  logic             busy_d;
  logic [OP_W-1:0]  op_d;
  logic [ARG_W-1:0] arg_d;
  logic [RES_W-1:0] res_d;

  always_comb begin
    keyed  = cmd_wr && (wd_key == CMD_KEY);
    op_ok  = op_defined(8'(wd_op));
    launch = keyed && op_ok && !busy_q;
    reject = keyed && (!op_ok || busy_q);

    busy_d = busy_q;
    if (launch)        busy_d = 1'b1;
    else if (eng_done) busy_d = 1'b0;

    op_d  = launch ? wd_op  : op_q;
    arg_d = launch ? wd_arg : arg_q;
    res_d = (eng_done && busy_q) ? eng_result : res_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      op_q    <= '0;
      arg_q   <= '0;
      res_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      start_q <= launch;
      op_q    <= op_d;
      arg_q   <= arg_d;
      res_q   <= res_d;
    end
  end

endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
  import fcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_i,
  input  logic             busy,
  input  logic             launch,
  input  logic             reject,
  input  logic             cmd_wr,
  input  logic             stat_rd,
  input  logic             lock_in,
  input  logic             flash_in,
  input  logic [ECC_N-1:0] ecc_in,
  output logic             ready,
  output logic             cmd_err_q,
  output logic [31:0]      stat_word
);

  localparam int unsigned HI_PAD = 32 - ECC_BASE - ECC_N;

  logic             cmd_err_d;
  logic             lock_q, lock_d;
  logic             flash_q, flash_d;
  logic [ECC_N-1:0] ecc_q;

  always_comb begin
    ready = !busy;

    cmd_err_d = cmd_err_q;
    if (reject)                  cmd_err_d = 1'b1;
    else if (cmd_wr || stat_rd)  cmd_err_d = 1'b0;

    lock_d = lock_q;
    if (lock_in)      lock_d = 1'b1;
    else if (stat_rd) lock_d = 1'b0;

    flash_d = flash_q;
    if (flash_in)    flash_d = 1'b1;
    else if (launch) flash_d = 1'b0;

    stat_word = {{HI_PAD{1'b0}}, ecc_q, {(ECC_BASE-4){1'b0}},
                 flash_q, lock_q, cmd_err_q, ready};
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cmd_err_q <= 1'b0;
      lock_q    <= 1'b0;
      flash_q   <= 1'b0;
    end else begin
      cmd_err_q <= cmd_err_d;
      lock_q    <= lock_d;
      flash_q   <= flash_d;
    end
  end

  for (genvar g = 0; g < ECC_N; g++) begin : g_ecc
    logic e_d;
    always_comb begin
      e_d = ecc_q[g];
      if (ecc_in[g])    e_d = 1'b1;
      else if (stat_rd) e_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) ecc_q[g] <= 1'b0;
      else        ecc_q[g] <= e_d;
    end
  end

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import fcmd_pkg::*;
#(
  parameter logic [11:0] VERSION = 12'h13A,
  parameter logic [2:0]  FIX     = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              eng_start,
  output logic [7:0]        eng_opcode,
  output logic [15:0]       eng_arg,
  input  logic              eng_done,
  input  logic [31:0]       eng_result,
  input  logic              eng_lock_err,
  input  logic              eng_flash_err,
  input  logic [ECC_N-1:0]  ecc_err,
  output logic [WS_W-1:0]   cfg_ws,
  output logic              cfg_seq_dis,
  output logic              cfg_loop_en,
  output logic              irq
);

  logic [1:0]  rst_sync;
  logic        rst_i;
  logic        mode_wr, prot_wr, cmd_wr, stat_rd;
  logic        launch, reject, busy, ready, cmd_err;
  logic        prot_en;
  mode_t       mode;
  logic [31:0] stat_word;
  logic [31:0] res_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  always_comb begin
    mode_wr = bus_wr && (bus_addr == OFS_MODE);
    prot_wr = bus_wr && (bus_addr == OFS_PROT);
    cmd_wr  = bus_wr && (bus_addr == OFS_CMD);
    stat_rd = bus_rd && (bus_addr == OFS_STAT);
  end

  fcmd_cfg u_cfg (
    .clk       (clk),
    .rst_i     (rst_i),
    .mode_wr   (mode_wr),
    .prot_wr   (prot_wr),
    .wd_ie     (bus_wdata[0]),
    .wd_ws     (bus_wdata[11:8]),
    .wd_seq    (bus_wdata[16]),
    .wd_loop   (bus_wdata[26]),
    .wd_pkey   (bus_wdata[31:8]),
    .mode_q    (mode),
    .prot_en_q (prot_en)
  );

  fcmd_launch #(.OP_W(8), .ARG_W(16), .RES_W(32)) u_launch (
    .clk        (clk),
    .rst_i      (rst_i),
    .cmd_wr     (cmd_wr),
    .wd_key     (bus_wdata[31:24]),
    .wd_op      (bus_wdata[7:0]),
    .wd_arg     (bus_wdata[23:8]),
    .eng_done   (eng_done),
    .eng_result (eng_result),
    .launch     (launch),
    .reject     (reject),
    .busy_q     (busy),
    .start_q    (eng_start),
    .op_q       (eng_opcode),
    .arg_q      (eng_arg),
    .res_q      (res_word)
  );

  fcmd_status u_status (
    .clk       (clk),
    .rst_i     (rst_i),
    .busy      (busy),
    .launch    (launch),
    .reject    (reject),
    .cmd_wr    (cmd_wr),
    .stat_rd   (stat_rd),
    .lock_in   (eng_lock_err),
    .flash_in  (eng_flash_err),
    .ecc_in    (ecc_err),
    .ready     (ready),
    .cmd_err_q (cmd_err),
    .stat_word (stat_word)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_MODE: bus_rdata = {5'b0, mode.loop_en, 9'b0, mode.seq_dis,
                             4'b0, mode.ws, 7'b0, mode.rdy_ie};
      OFS_STAT: bus_rdata = stat_word;
      OFS_RES:  bus_rdata = res_word;
      OFS_VER:  bus_rdata = {13'b0, FIX, 4'b0, VERSION};
      OFS_PROT: bus_rdata = {31'b0, prot_en};
      default:  bus_rdata = 32'h0;
    endcase
    cfg_ws      = mode.ws;
    cfg_seq_dis = mode.seq_dis;
    cfg_loop_en = mode.loop_en;
    irq         = ready && mode.rdy_ie;
  end

endmodule

// File: rtl/fcmd_checker.sv
module fcmd_checker
  import fcmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              eng_start,
  input logic              ready,
  input logic              cmd_err,
  input logic              prot_en,
  input logic [WS_W-1:0]   cfg_ws
);

  p_key_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(bus_wr && bus_addr == OFS_CMD && bus_wdata[31:24] == CMD_KEY));

  p_badkey_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CMD && bus_wdata[31:24] != CMD_KEY) |=> !eng_start);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_not_ready_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !ready);

  p_bad_op_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CMD && bus_wdata[31:24] == CMD_KEY
     && !op_defined(bus_wdata[7:0])) |=> (cmd_err && !eng_start));

  p_mode_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && bus_wr && bus_addr == OFS_MODE) |=> $stable(cfg_ws));

endmodule

bind flash_cmd_frontend fcmd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .eng_start (eng_start),
  .ready     (ready),
  .cmd_err   (cmd_err),
  .prot_en   (prot_en),
  .cfg_ws    (cfg_ws)
);

// File: tb/sim_flash_cmd_frontend.sv
`timescale 1ns/1ps
module sim_flash_cmd_frontend;
  import fcmd_pkg::*;

  localparam logic [11:0] VER = 12'h13A;
  localparam logic [2:0]  FX  = 3'd2;
  localparam int LAT = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        eng_start, eng_done;
  logic [7:0]  eng_opcode;
  logic [15:0] eng_arg;
  logic [31:0] eng_result;
  logic        eng_lock_err, eng_flash_err;
  logic [3:0]  ecc_err;
  logic [3:0]  cfg_ws;
  logic        cfg_seq_dis, cfg_loop_en, irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  flash_cmd_frontend #(.VERSION(VER), .FIX(FX)) u0 (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares every read strobe against the queued expectation
  always @(negedge clk) begin
    #2;
    if (bus_rd && exp_q.size() > 0) chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // flash engine stub
  initial begin
    int cnt = 0;
    eng_done = 1'b0; eng_result = '0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (eng_start) begin
        cnt = LAT;
        eng_result = {eng_opcode, eng_arg, 8'h3C};
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) eng_done = 1'b1;
      end
    end
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    eng_lock_err = 0; eng_flash_err = 0; ecc_err = '0;
    idle(4); rst_n = 1'b1; idle(3);

    // R11 reset state
    rd(OFS_STAT, 32'h1, "R11 status");
    rd(OFS_MODE, 32'h0, "R11 mode");
    rd(OFS_PROT, 32'h0, "R11 prot");
    rd(OFS_RES,  32'h0, "R11 result");
    chk({31'b0, eng_start}, 32'h0, "R11 start");
    chk({31'b0, irq}, 32'h0, "R11 irq");

    // R9 version and unmapped
    rd(OFS_VER, {13'b0, FX, 4'b0, VER}, "R9 version");
    rd(8'h10, 32'h0, "R9 unmapped");

    // R8 mode fields
    wr(OFS_MODE, 32'hFFFF_FFFF);
    rd(OFS_MODE, 32'h0401_0F01, "R8 mode all");
    chk({28'b0, cfg_ws}, 32'hF, "R8 cfg_ws");
    chk({30'b0, cfg_seq_dis, cfg_loop_en}, 32'h3, "R8 cfg bits");
    chk({31'b0, irq}, 32'h1, "R10 irq idle enabled");

    // R7 protection key, R8 lock
    wr(OFS_PROT, 32'h1234_5601);
    rd(OFS_PROT, 32'h0, "R7 bad key");
    wr(OFS_PROT, 32'h4546_43FF);
    rd(OFS_PROT, 32'h1, "R7 good key readback");
    wr(OFS_MODE, 32'h0);
    rd(OFS_MODE, 32'h0401_0F01, "R8 write ignored when protected");
    wr(OFS_PROT, 32'h4546_4300);
    rd(OFS_PROT, 32'h0, "R7 disable");
    wr(OFS_MODE, 32'h0000_0301);
    rd(OFS_MODE, 32'h0000_0301, "R8 write after unprotect");
    chk({28'b0, cfg_ws}, 32'h3, "R8 cfg_ws 3");

    // R1 wrong key
    wr(OFS_CMD, 32'h5B12_3401);
    chk({31'b0, eng_start}, 32'h0, "R1 wrong key no start");
    rd(OFS_STAT, 32'h1, "R1 wrong key no error");

    // R2/R3 launch, R4 busy rejection
    wr(OFS_CMD, 32'h5A12_3401);
    chk({31'b0, eng_start}, 32'h1, "R2 start strobe");
    chk({24'b0, eng_opcode}, 32'h01, "R2 opcode");
    chk({16'b0, eng_arg}, 32'h1234, "R2 argument");
    chk({31'b0, irq}, 32'h0, "R10 irq while busy");
    idle(1);
    chk({31'b0, eng_start}, 32'h0, "R2 single-cycle strobe");
    rd(OFS_STAT, 32'h0, "R3 not ready while busy");
    wr(OFS_CMD, 32'h5A00_0005);
    chk({31'b0, eng_start}, 32'h0, "R4 busy write no start");
    chk({24'b0, eng_opcode}, 32'h01, "R2 opcode held");
    idle(14);
    rd(OFS_STAT, 32'h3, "R4 busy error and R3 ready again");
    rd(OFS_STAT, 32'h1, "R4 cleared by read");
    rd(OFS_RES, 32'h0112_343C, "R3 result captured");

    // R4 undefined opcodes, cleared by command write
    wr(OFS_CMD, 32'h5A00_0006);
    chk({31'b0, eng_start}, 32'h0, "R4 opcode 06 no start");
    rd(OFS_STAT, 32'h3, "R4 opcode 06 error");
    wr(OFS_CMD, 32'h0000_0000);
    rd(OFS_STAT, 32'h1, "R4 cleared by command write");
    wr(OFS_CMD, 32'h5A00_0016);
    rd(OFS_STAT, 32'h3, "R4 opcode 16 error");
    rd(OFS_STAT, 32'h1, "R4 read clears");

    // R5 lock and ECC sticky flags
    @(negedge clk); eng_lock_err = 1'b1; ecc_err = 4'hA;
    @(negedge clk); eng_lock_err = 1'b0; ecc_err = 4'h0;
    idle(2);
    rd(OFS_STAT, 32'h000A_0005, "R5 lock and ecc sticky");
    rd(OFS_STAT, 32'h1, "R5 cleared on read");
    @(negedge clk); ecc_err = 4'h1; bus_addr = OFS_STAT; bus_rd = 1'b1;
    exp_q.push_back(32'h1); tag_q.push_back("R5 read in set cycle");
    @(negedge clk); ecc_err = 4'h0; bus_rd = 1'b0;
    rd(OFS_STAT, 32'h0001_0001, "R5 set wins over read clear");
    rd(OFS_STAT, 32'h1, "R5 cleared afterwards");

    // R6 flash error cleared only by launch
    @(negedge clk); eng_flash_err = 1'b1;
    @(negedge clk); eng_flash_err = 1'b0;
    rd(OFS_STAT, 32'h9, "R6 flash error set");
    rd(OFS_STAT, 32'h9, "R6 not cleared by read");
    wr(OFS_CMD, 32'h5ABE_EF11);
    chk({24'b0, eng_opcode}, 32'h11, "R2 opcode 11");
    chk({16'b0, eng_arg}, 32'hBEEF, "R2 argument BEEF");
    idle(14);
    rd(OFS_STAT, 32'h1, "R6 cleared on launch");
    rd(OFS_RES, 32'h11BE_EF3C, "R3 second result");

    // R10 interrupt follows enable
    chk({31'b0, irq}, 32'h1, "R10 irq ready enabled");
    wr(OFS_MODE, 32'h0);
    chk({31'b0, irq}, 32'h0, "R10 irq disabled");

    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule